// File: doc/BRIEF.md
# Serial Packet Descrambler with Access Gate

This block sits inline in a serial packet stream. It takes one bit per clock. A start marker flags the first header bit of each packet, and a subframe flag comes with that marker. The header is sent in clear. It carries a 10-bit packet address and an 8-bit packet-type byte, followed by spare bits.

While the header is arriving, the block compares the address against four programmed entries. Each entry holds an address, a subframe location mask, an enable flag, an automatic-mode flag, a deny flag and a 15-bit keystream seed. The block decides before the first payload bit what happens to the 720 payload bits that follow:

- They pass unchanged.
- They are XORed with a keystream seeded from the matching entry.
- They are forced to ones, which blanks a denied service while keeping the packet in the stream.

Every bit leaves the block exactly four clocks after it entered. This holds whether the bit belongs to a matched packet, an unmatched packet or the idle gap between packets. Entries are written through a simple single-cycle write port.

Top module: `pkt_descrambler`

## Requirements
- R1: Header bit positions are counted from 0, where position 0 is the bit presented with `pkt_start_i`. Positions 0..9 carry the packet address, least significant bit first. A packet matches entry k when entry k is enabled, its location mask permits the packet's subframe, and the address compares equal. If several entries match, the lowest index wins. Writing an entry with enable 0 removes it from matching.
- R2: For a matched packet that is neither denied nor of a bypass type, payload bit j is XORed with key bit j. Payload bits are header positions 23..742, and j counts from 0 at position 23. The key comes from a 15-bit register s, loaded with the entry seed before payload bit 0. Each key bit is s[14], and after each payload bit s becomes {s[13:0], s[14]^s[13]}. Header bits are never altered.
- R3: The packet-type byte occupies header positions 10..17, least significant bit first. If its value is 0x00 or 0x3F, the payload of a matched, non-denied packet passes unchanged.
- R4: When an entry's automatic flag is set, address bits 3..6 are excluded from its comparison. Bits 0..2 and 7..9 must still agree.
- R5: `subframe_i` is sampled with `pkt_start_i`. Location mask bit 0 enables an entry in subframe 0, and bit 1 enables it in subframe 1. Recognition is repeated for every packet.
- R6: When the matched entry has its deny flag set, all 720 payload bits are output as 1. This takes priority over descrambling and over the bypass packet types.
- R7: Every input bit appears at `bit_o` exactly four clocks later. Bits of unmatched packets and bits outside packets are unchanged.
- R8: While reset is asserted, `bit_o` is 0 and all four entries are cleared to disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_i | input | 1 | Serial input stream |
| pkt_start_i | input | 1 | Marks header position 0 |
| subframe_i | input | 1 | Subframe of the packet, sampled with pkt_start_i |
| cfg_we_i | input | 1 | Entry write strobe |
| cfg_idx_i | input | 2 | Entry index to write |
| cfg_addr_i | input | 10 | Entry packet address |
| cfg_loc_i | input | 2 | Entry subframe location mask |
| cfg_en_i | input | 1 | Entry enable |
| cfg_auto_i | input | 1 | Entry automatic mode: ignore centre address bits |
| cfg_deny_i | input | 1 | Entry deny flag: force payload to ones |
| cfg_seed_i | input | 15 | Entry keystream seed |
| bit_o | output | 1 | Processed serial stream, four clocks late |

## Verification
The access gate and the descrambler can both claim the same payload bit when a denied entry matches a packet that also carries a seed. A denied packet whose type byte is a bypass value adds the type decode as a third claimant on those bits. The bench sends a denied entry with a nonzero seed under both an ordinary and a bypass type byte. It expects every payload bit to be 1, with no trace of the keystream. The checker also requires that at most one of gate, descramble and bypass is active in any payload cycle.

// File: rtl/pkt_descr_pkg.sv
package pkt_descr_pkg;
  localparam int ADDR_W = 10;
  localparam int PT_W   = 8;
  localparam int SEED_W = 15;
  localparam int N_ENT  = 4;
  localparam int IDX_W  = $clog2(N_ENT);
  localparam int LOC_W  = 2;

  localparam logic [PT_W-1:0] PT_BYP_A = 8'h00;
  localparam logic [PT_W-1:0] PT_BYP_B = 8'h3F;

  typedef struct packed {
    logic              en;
    logic              auto_m;
    logic              deny;
    logic [LOC_W-1:0]  loc;
    logic [ADDR_W-1:0] addr;
    logic [SEED_W-1:0] seed;
  } entry_t;
endpackage

// File: rtl/pkt_entry_regs.sv
module pkt_entry_regs
  import pkt_descr_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  entry_t                 wdata_i,
  output entry_t [N_ENT-1:0]     ent_o
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    entry_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              ent_q <= '0;
      else if (we_i && idx_i == IDX_W'(g))      ent_q <= wdata_i;
    end
    assign ent_o[g] = ent_q;
  end
endmodule

// File: rtl/pkt_addr_match.sv
module pkt_addr_match
  import pkt_descr_pkg::*;
(
  input  entry_t [N_ENT-1:0] ent_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               sf_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  localparam int CTR_LO = (ADDR_W - 4) / 2;
  localparam logic [ADDR_W-1:0] CTR_MASK = ADDR_W'(15) << CTR_LO;

  logic [N_ENT-1:0] hit_v;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    logic [ADDR_W-1:0] care;
    assign care     = ent_i[g].auto_m ? ~CTR_MASK : '1;
    assign hit_v[g] = ent_i[g].en && ent_i[g].loc[sf_i] &&
                      (((addr_i ^ ent_i[g].addr) & care) == '0);
  end

  // lowest index wins
  always_comb begin
    hit_o = |hit_v;
    idx_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_v[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pkt_keystream.sv
module pkt_keystream #(
  parameter int W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  output logic         key_o
);
  logic [W-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     s_q <= '0;
    else if (load_i) s_q <= seed_i;
    else if (step_i) s_q <= {s_q[W-2:0], s_q[W-1] ^ s_q[W-2]};
  end

  assign key_o = s_q[W-1];
endmodule

// File: rtl/pkt_descrambler.sv
module pkt_descrambler
  import pkt_descr_pkg::*;
#(
  parameter int HDR_BITS = 23,
  parameter int PAY_BITS = 720,
  parameter int LAT      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              pkt_start_i,
  input  logic              subframe_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [LOC_W-1:0]  cfg_loc_i,
  input  logic              cfg_en_i,
  input  logic              cfg_auto_i,
  input  logic              cfg_deny_i,
  input  logic [SEED_W-1:0] cfg_seed_i,
  output logic              bit_o
);
  localparam int TOT   = HDR_BITS + PAY_BITS;
  localparam int POS_W = $clog2(TOT + 1);
  localparam int HW    = ADDR_W + PT_W;

  // entry storage
  entry_t             cfg_w;
  entry_t [N_ENT-1:0] ent;

  always_comb begin
    cfg_w        = '0;
    cfg_w.en     = cfg_en_i;
    cfg_w.auto_m = cfg_auto_i;
    cfg_w.deny   = cfg_deny_i;
    cfg_w.loc    = cfg_loc_i;
    cfg_w.addr   = cfg_addr_i;
    cfg_w.seed   = cfg_seed_i;
  end

  pkt_entry_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .idx_i   (cfg_idx_i),
    .wdata_i (cfg_w),
    .ent_o   (ent)
  );

  // bit position tracking
  logic [POS_W-1:0] pos_q, cur;
  logic             busy_q, cur_vld, sf_q;
  logic [HW-1:0]    hdr_q;

  assign cur_vld = pkt_start_i | busy_q;
  assign cur     = pkt_start_i ? '0 : pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      busy_q <= 1'b0;
      sf_q   <= 1'b0;
      hdr_q  <= '0;
    end else begin
      if (pkt_start_i) sf_q <= subframe_i;
      if (cur_vld && cur < POS_W'(HW)) hdr_q <= {bit_i, hdr_q[HW-1:1]};
      if (cur_vld) begin
        if (cur == POS_W'(TOT - 1)) begin
          busy_q <= 1'b0;
        end else begin
          busy_q <= 1'b1;
          pos_q  <= cur + 1'b1;
        end
      end
    end
  end

  // recognition, decided on the last header bit
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  entry_t           sel;
  logic             pt_byp, dec;

  pkt_addr_match u_match (
    .ent_i  (ent),
    .addr_i (hdr_q[ADDR_W-1:0]),
    .sf_i   (sf_q),
    .hit_o  (hit),
    .idx_o  (hit_idx)
  );

  assign sel    = ent[hit_idx];
  assign pt_byp = (hdr_q[HW-1:ADDR_W] == PT_BYP_A) || (hdr_q[HW-1:ADDR_W] == PT_BYP_B);
  assign dec    = cur_vld && (cur == POS_W'(HDR_BITS - 1));

  logic gate_q, descr_q, byp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q  <= 1'b0;
      descr_q <= 1'b0;
      byp_q   <= 1'b0;
    end else if (pkt_start_i) begin
      gate_q  <= 1'b0;
      descr_q <= 1'b0;
      byp_q   <= 1'b0;
    end else if (dec) begin
      gate_q  <= hit & sel.deny;
      descr_q <= hit & ~sel.deny & ~pt_byp;
      byp_q   <= hit & ~sel.deny & pt_byp;
    end
  end

  logic pay_act, gate_act, descr_act, byp_act, key_bit;

  assign pay_act   = cur_vld && (cur >= POS_W'(HDR_BITS));
  assign gate_act  = pay_act & gate_q;
  assign descr_act = pay_act & descr_q;
  assign byp_act   = pay_act & byp_q;

  pkt_keystream #(.W(SEED_W)) u_key (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (dec),
    .seed_i (sel.seed),
    .step_i (pay_act),
    .key_o  (key_bit)
  );

  // process at entry, then fixed delay line
  logic           s0;
  logic [LAT-1:0] pipe_q;

  assign s0 = gate_act | (bit_i ^ (descr_act & key_bit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[LAT-2:0], s0};
  end

  assign bit_o = pipe_q[LAT-1];
endmodule

// File: rtl/pkt_descrambler_chk.sv
module pkt_descrambler_chk #(
  parameter int LAT = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_i,
  input logic bit_o,
  input logic pay_act,
  input logic gate_act,
  input logic descr_act,
  input logic byp_act,
  input logic key_bit
);
  logic [LAT-1:0] in_d, pay_d, gate_d, descr_d, byp_d, ref_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_d <= '0; pay_d <= '0; gate_d <= '0; descr_d <= '0; byp_d <= '0; ref_d <= '0;
    end else begin
      in_d    <= {in_d[LAT-2:0], bit_i};
      pay_d   <= {pay_d[LAT-2:0], pay_act};
      gate_d  <= {gate_d[LAT-2:0], gate_act};
      descr_d <= {descr_d[LAT-2:0], descr_act};
      byp_d   <= {byp_d[LAT-2:0], byp_act};
      ref_d   <= {ref_d[LAT-2:0], bit_i ^ key_bit};
    end
  end

  // R7
  pass_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pay_d[LAT-1] |-> bit_o == in_d[LAT-1]);

  // R6
  gate_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_d[LAT-1] |-> bit_o);

  // R3
  bypass_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_d[LAT-1] |-> bit_o == in_d[LAT-1]);

  // R2
  key_xor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    descr_d[LAT-1] |-> bit_o == ref_d[LAT-1]);

  // R6
  mode_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({gate_act, descr_act, byp_act}));

  // R8
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_out_chk: assert (bit_o == 1'b0) else $error("reset output not low");
    end
  end
endmodule

bind pkt_descrambler pkt_descrambler_chk #(.LAT(LAT)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_i     (bit_i),
  .bit_o     (bit_o),
  .pay_act   (pay_act),
  .gate_act  (gate_act),
  .descr_act (descr_act),
  .byp_act   (byp_act),
  .key_bit   (key_bit)
);

// File: tb/pkt_descrambler_tb_top.sv
module pkt_descrambler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HDR = 23;
  localparam int PAY = 720;
  localparam int TOT = HDR + PAY;

  typedef struct packed {
    logic [9:0]  addr;
    logic [7:0]  pt;
    logic        sf;
    logic [1:0]  mode;   // 0 pass, 1 descramble, 2 ones
    logic [14:0] seed;
    logic [7:0]  req;
  } vec_t;

  // entries: e0 155 both, e1 2A3 sf1 only, e2 3C1 auto, e3 0F0 deny
  localparam vec_t VECS [10] = '{
    '{10'h155, 8'h12, 1'b0, 2'd1, 15'h1ACE, 8'd1},  // R1 R2
    '{10'h155, 8'h00, 1'b0, 2'd0, 15'h1ACE, 8'd3},  // R3
    '{10'h155, 8'h3F, 1'b1, 2'd0, 15'h1ACE, 8'd3},  // R3
    '{10'h2A3, 8'h12, 1'b0, 2'd0, 15'h0F0F, 8'd5},  // R5 wrong subframe
    '{10'h2A3, 8'h55, 1'b1, 2'd1, 15'h0F0F, 8'd5},  // R5
    '{10'h3B9, 8'h21, 1'b0, 2'd1, 15'h7001, 8'd4},  // R4 centre bits differ
    '{10'h3C0, 8'h21, 1'b0, 2'd0, 15'h7001, 8'd4},  // R4 outer bit differs
    '{10'h0F0, 8'h12, 1'b1, 2'd2, 15'h1234, 8'd6},  // R6
    '{10'h0F0, 8'h00, 1'b0, 2'd2, 15'h1234, 8'd6},  // R6 over bypass type
    '{10'h100, 8'h12, 1'b0, 2'd0, 15'h0000, 8'd7}   // R7 unmatched
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_i = 1'b0, pkt_start = 1'b0, subframe = 1'b0;
  logic cfg_we = 1'b0, cfg_en = 1'b0, cfg_auto = 1'b0, cfg_deny = 1'b0;
  logic [1:0] cfg_idx = '0, cfg_loc = '0;
  logic [9:0] cfg_addr = '0;
  logic [14:0] cfg_seed = '0;
  logic bit_o;

  int checks = 0, fails = 0, cyc = 0, bit_err = 0;
  logic exp_r [8];
  bit   vld_r [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_descrambler dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bit_i(bit_i), .pkt_start_i(pkt_start),
    .subframe_i(subframe), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_addr_i(cfg_addr), .cfg_loc_i(cfg_loc), .cfg_en_i(cfg_en),
    .cfg_auto_i(cfg_auto), .cfg_deny_i(cfg_deny), .cfg_seed_i(cfg_seed),
    .bit_o(bit_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic st, input logic sf, input logic e);
    @(negedge clk);
    if (cyc >= 4 && vld_r[(cyc-4)%8] && bit_o !== exp_r[(cyc-4)%8]) bit_err++;
    bit_i = b; pkt_start = st; subframe = sf;
    exp_r[cyc%8] = e; vld_r[cyc%8] = 1'b1;
    cyc++;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    bit_i = 1'b0; pkt_start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 reset output", int'(bit_o), 0);
    for (int i = 0; i < 8; i++) vld_r[i] = 1'b0;
    rst_ni = 1'b1;
  endtask

  task automatic cfg(input int idx, input logic [9:0] a, input logic [1:0] loc,
                     input logic en, input logic au, input logic dn, input logic [14:0] sd);
    cfg_idx = 2'(idx); cfg_addr = a; cfg_loc = loc;
    cfg_en = en; cfg_auto = au; cfg_deny = dn; cfg_seed = sd;
    cfg_we = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0);
    cfg_we = 1'b0;
  endtask

  task automatic send_pkt(input logic [9:0] a, input logic [7:0] pt, input logic sf,
                          input logic [1:0] mode, input logic [14:0] seed, input string tag);
    logic [14:0] s;
    logic b, e;
    s = seed;
    bit_err = 0;
    for (int i = 0; i < TOT; i++) begin
      if (i < 10)       b = a[i];
      else if (i < 18)  b = pt[i-10];
      else              b = ((i * 5 + int'(a)) % 3) == 0;
      e = b;
      if (i >= HDR) begin
        if (mode == 2'd1) e = b ^ s[14];
        else if (mode == 2'd2) e = 1'b1;
        s = {s[13:0], s[14] ^ s[13]};
      end
      step(b, i == 0, sf, e);
    end
    for (int i = 0; i < 4; i++) step(1'(i % 2), 1'b0, 1'b0, 1'(i % 2));
    chk(tag, bit_err, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) vld_r[i] = 1'b0;
    do_reset();
    // R8: entries cleared by reset
    cfg(0, 10'h155, 2'b11, 1'b1, 1'b0, 1'b0, 15'h1ACE);
    do_reset();
    send_pkt(10'h155, 8'h12, 1'b0, 2'd0, 15'h0, "R8 entries cleared");

    cfg(0, 10'h155, 2'b11, 1'b1, 1'b0, 1'b0, 15'h1ACE);
    cfg(1, 10'h2A3, 2'b10, 1'b1, 1'b0, 1'b0, 15'h0F0F);
    cfg(2, 10'h3C1, 2'b11, 1'b1, 1'b1, 1'b0, 15'h7001);
    cfg(3, 10'h0F0, 2'b11, 1'b1, 1'b0, 1'b1, 15'h1234);

    for (int v = 0; v < 10; v++) begin
      send_pkt(VECS[v].addr, VECS[v].pt, VECS[v].sf, VECS[v].mode, VECS[v].seed,
               $sformatf("R%0d vector %0d", VECS[v].req, v));
    end

    // R2: keystream reseeded for each packet, back to back
    send_pkt(10'h155, 8'h44, 1'b1, 2'd1, 15'h1ACE, "R2 reseed");
    // R1: disabled entry no longer matches
    cfg(0, 10'h155, 2'b11, 1'b0, 1'b0, 1'b0, 15'h1ACE);
    send_pkt(10'h155, 8'h12, 1'b0, 2'd0, 15'h0, "R1 disabled entry");
    // R7: idle stream delayed only
    bit_err = 0;
    for (int i = 0; i < 40; i++) step(1'((i * 3) % 5 == 1), 1'b0, 1'b0, 1'((i * 3) % 5 == 1));
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 idle delay", bit_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule